// File: doc/BRIEF.md
# Serial Port Receive Status and Interrupt Unit

This block sits behind the receive pin of a frame-synchronized synchronous serial port. A small serial-to-parallel stage collects one word per frame and hands it to a receive data register. The block tracks whether that register holds unread data and detects an overrun. It raises one of two prioritized interrupt requests: an exception request when the data is overrun, and a plain receive request when the data is clean.

An overrun is cleared only by a two-step access. Software first reads the status and then reads the data. A data read on its own empties the register but leaves the error standing. A port-enable input acts as an individual reset of the port. While it is low, all receive state is held idle and the word-length setting is captured. While the port runs, only the two interrupt enables and the receive enable may change.

Serial clock edges arrive as a one-cycle strobe in the system clock domain. Each strobe samples the data and frame-sync pins once.

Top module: `ser_rx_stat`

## Requirements
- R1: While `rst_n` or `port_en` is low, `rx_full`, `rx_ovr`, both interrupt outputs and `irq_code` are 0, and `rx_data` reads 0.
- R2: A word starts only on a `sclk_tick` cycle where `fsync` and `rx_en` are both high. Ticks without frame sync, or with `rx_en` low, never fill the register.
- R3: A word is `L` bits shifted MSB first, one bit per tick, and the bit on the frame-sync tick is the first bit. The result appears right-aligned in `rx_data`, with `rx_full` set, two clock cycles after its last tick. `L` is `cfg_word_len`, and 0 or any value above `W` means `W`.
- R4: A frame sync that arrives while a word is in progress is ignored. The word completes after its full `L` bits.
- R5: When a word completes while `rx_full` is set and no data read happens in that cycle, `rx_ovr` is set and the new word replaces the register contents.
- R6: `irq_exc` is high exactly when `ie_exc`, `rx_full` and `rx_ovr` are all high.
- R7: `irq_rx` is high exactly when `ie_rx` and `rx_full` are high and `rx_ovr` is low.
- R8: A `rd_data` pulse clears `rx_full`, and with it `irq_rx`, unless a word completes in the same cycle.
- R9: `rx_ovr` clears only when a `rd_data` pulse follows a `rd_status` pulse that saw the overrun, with no data read in between. A data read with no prior status read leaves `rx_ovr` set.
- R10: `cfg_word_len` is captured only while `port_en` is low. Changes made while the port is enabled have no effect.
- R11: `ie_exc`, `ie_rx` and `rx_en` take effect while the port stays enabled, without an individual reset.
- R12: `irq_code` is 2'b10 for the exception request, 2'b01 for the plain receive request and 2'b00 for none. At most one request is presented at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| port_en | input | 1 | Port enable; low holds the individual reset state |
| cfg_word_len | input | LEN_W | Word length in bits, captured while the port is disabled |
| rx_en | input | 1 | Receive enable |
| ie_exc | input | 1 | Exception interrupt enable |
| ie_rx | input | 1 | Plain receive interrupt enable |
| sclk_tick | input | 1 | One-cycle strobe marking a serial clock sampling edge |
| fsync | input | 1 | Frame sync pin, sampled on ticks |
| sdata | input | 1 | Serial data pin, sampled on ticks |
| rd_status | input | 1 | One-cycle status read strobe |
| rd_data | input | 1 | One-cycle data register read strobe |
| rx_data | output | W | Receive data register |
| rx_full | output | 1 | Receive register holds unread data |
| rx_ovr | output | 1 | Overrun flag |
| irq_exc | output | 1 | Receive-with-exception interrupt request |
| irq_rx | output | 1 | Plain receive interrupt request |
| irq_code | output | 2 | Encoded active request after priority |

## Verification
The bench builds the block with `W = 8`, so a full word takes eight ticks. This keeps overrun scenarios of two back-to-back frames short. It also makes `cfg_word_len` values above `W` (up to 15) reachable, so the fallback to full width can be exercised. A 4-bit word length is used to show that the setting changes only across an individual reset.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'b00,
    IRQ_RX   = 2'b01,
    IRQ_EXC  = 2'b10
  } irq_code_e;

  // Effective word length: out-of-range settings fall back to full width.
  function automatic int unsigned eff_len(int unsigned setting, int unsigned width);
    if (setting == 0 || setting > width) return width;
    return setting;
  endfunction

  // Next state of the two-step overrun clear arming.
  function automatic logic next_armed(logic armed, logic ovr, logic rd_st, logic rd_dt);
    if (rd_dt) return 1'b0;
    if (rd_st) return ovr;
    return armed;
  endfunction

endpackage

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
  parameter int W     = 24,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [LEN_W-1:0] len,
  input  logic             rx_en,
  input  logic             sclk_tick,
  input  logic             fsync,
  input  logic             sdata,
  output logic             word_done,
  output logic [W-1:0]     word
);

  logic [W-1:0]     sh_q;
  logic [LEN_W-1:0] cnt_q;
  logic             busy_q;
  logic             start_w;
  logic             last_w;
  logic [W-1:0]     shifted_w;

  // A frame sync is honoured only when idle; mid-word syncs fall through.
  assign start_w   = sclk_tick && !busy_q && fsync && rx_en;
  assign shifted_w = start_w ? {{(W-1){1'b0}}, sdata} : {sh_q[W-2:0], sdata};
  assign last_w    = (start_w && len == LEN_W'(1)) ||
                     (busy_q && sclk_tick && (cnt_q + LEN_W'(1)) == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      word_done <= 1'b0;
      word      <= '0;
    end else if (!port_en) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      word_done <= 1'b0;
      if (sclk_tick && (start_w || busy_q)) begin
        sh_q <= shifted_w;
        if (last_w) begin
          busy_q    <= 1'b0;
          cnt_q     <= '0;
          word_done <= 1'b1;
          word      <= shifted_w;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= start_w ? LEN_W'(1) : cnt_q + LEN_W'(1);
        end
      end
    end
  end

  AST_START_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(sclk_tick && fsync && rx_en && port_en)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R3

endmodule

// File: rtl/ser_rx_status.sv
module ser_rx_status #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         port_en,
  input  logic         word_done,
  input  logic [W-1:0] word,
  input  logic         rd_status,
  input  logic         rd_data,
  output logic [W-1:0] rx_data,
  output logic         rx_full,
  output logic         rx_ovr
);

  import ser_rx_pkg::*;

  logic armed_q;
  logic clear_ovr_w;
  logic set_ovr_w;

  assign set_ovr_w   = word_done && rx_full && !rd_data;
  assign clear_ovr_w = rd_data && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!port_en) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= next_armed(armed_q, rx_ovr, rd_status, rd_data);
      if (word_done) begin
        rx_data <= word;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (set_ovr_w)        rx_ovr <= 1'b1;
      else if (clear_ovr_w) rx_ovr <= 1'b0;
    end
  end

  AST_OVR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(word_done && rx_full)); // R5

  AST_OVR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en) && $fell(rx_ovr)) |-> $past(rd_data)); // R9

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !word_done) |=> !rx_full); // R8

endmodule

// File: rtl/ser_rx_irq.sv
module ser_rx_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ie_exc,
  input  logic       ie_rx,
  input  logic       rx_full,
  input  logic       rx_ovr,
  output logic       irq_exc,
  output logic       irq_rx,
  output logic [1:0] irq_code
);

  import ser_rx_pkg::*;

  assign irq_exc = ie_exc && rx_full && rx_ovr;
  assign irq_rx  = ie_rx && rx_full && !rx_ovr;

  always_comb begin
    if (irq_exc)     irq_code = IRQ_EXC;
    else if (irq_rx) irq_code = IRQ_RX;
    else             irq_code = IRQ_NONE;
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_exc, irq_rx})); // R12

  AST_RX_CLEAN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> !rx_ovr); // R7

  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == IRQ_EXC) |-> (ie_exc && rx_ovr)); // R6

endmodule

// File: rtl/ser_rx_stat.sv
module ser_rx_stat #(
  parameter int W = 24,
  localparam int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [LEN_W-1:0] cfg_word_len,
  input  logic             rx_en,
  input  logic             ie_exc,
  input  logic             ie_rx,
  input  logic             sclk_tick,
  input  logic             fsync,
  input  logic             sdata,
  input  logic             rd_status,
  input  logic             rd_data,
  output logic [W-1:0]     rx_data,
  output logic             rx_full,
  output logic             rx_ovr,
  output logic             irq_exc,
  output logic             irq_rx,
  output logic [1:0]       irq_code
);

  import ser_rx_pkg::*;

  logic [LEN_W-1:0] len_q;
  logic             word_done;
  logic [W-1:0]     word;

  // Control setting is frozen while the port runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        len_q <= LEN_W'(W);
    else if (!port_en) len_q <= LEN_W'(eff_len(int'(cfg_word_len), W));
  end

  ser_rx_shift #(.W(W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .len(len_q), .rx_en(rx_en),
    .sclk_tick(sclk_tick), .fsync(fsync), .sdata(sdata),
    .word_done(word_done), .word(word)
  );

  ser_rx_status #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .word_done(word_done),
    .word(word), .rd_status(rd_status), .rd_data(rd_data),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  ser_rx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ie_exc(ie_exc), .ie_rx(ie_rx),
    .rx_full(rx_full), .rx_ovr(rx_ovr),
    .irq_exc(irq_exc), .irq_rx(irq_rx), .irq_code(irq_code)
  );

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en)) |-> $stable(len_q)); // R10

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!port_en) |-> (!rx_full && !rx_ovr && irq_code == 2'b00)); // R1

endmodule

// File: tb/ser_rx_stat_tb.sv
module ser_rx_stat_tb_top;

  localparam int W         = 8;
  localparam int LEN_W     = $clog2(W + 1);
  localparam time CLK_PER  = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             port_en = 1'b0;
  logic [LEN_W-1:0] cfg_word_len = '0;
  logic             rx_en = 1'b0, ie_exc = 1'b0, ie_rx = 1'b0;
  logic             sclk_tick = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic             rd_status = 1'b0, rd_data = 1'b0;
  logic [W-1:0]     rx_data;
  logic             rx_full, rx_ovr, irq_exc, irq_rx;
  logic [1:0]       irq_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  ser_rx_stat #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_word_len(cfg_word_len),
    .rx_en(rx_en), .ie_exc(ie_exc), .ie_rx(ie_rx), .sclk_tick(sclk_tick),
    .fsync(fsync), .sdata(sdata), .rd_status(rd_status), .rd_data(rd_data),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr),
    .irq_exc(irq_exc), .irq_rx(irq_rx), .irq_code(irq_code)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench restatement of the interrupt rules (R6, R7, R12).
  function automatic int exp_code(bit ie_e, bit ie_r, bit full, bit ovr);
    if (ie_e && full && ovr) return 2;
    if (ie_r && full && !ovr) return 1;
    return 0;
  endfunction

  // Sends nbits of val MSB first on consecutive ticks; fsync on the first
  // bit when with_fs, plus an extra sync on bit index extra_fs (if >= 0).
  task automatic send(int val, int nbits, bit with_fs, int extra_fs);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sclk_tick = 1'b1;
      fsync     = (with_fs && i == 0) || (i == extra_fs);
      sdata     = val[nbits-1-i];
    end
    @(negedge clk);
    sclk_tick = 1'b0;
    fsync     = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 full", rx_full, 0);
    check("R1 ovr", rx_ovr, 0);
    check("R1 data", rx_data, 0);
    check("R1 code", irq_code, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 8, 1, -1);
    check("R3 data", rx_data, 8'hA5);
    check("R3 full", rx_full, 1);
    check("R7 irq_rx", irq_rx, 1);
    check("R12 code rx", irq_code, exp_code(1, 1, 1, 0));
    pulse_data();
    check("R8 full cleared", rx_full, 0);
    check("R8 irq_rx cleared", irq_rx, 0);
  endtask

  task automatic t_gating();
    send(8'hFF, 8, 0, -1);
    check("R2 no fsync", rx_full, 0);
    rx_en = 1'b0;
    send(8'h5A, 8, 1, -1);
    check("R2 rx_en low", rx_full, 0);
    rx_en = 1'b1;
    send(8'h69, 8, 1, -1);
    check("R11 rx_en back on", rx_data, 8'h69);
    pulse_data();
  endtask

  task automatic t_midsync();
    send(8'h9C, 8, 1, 3);
    check("R4 word intact", rx_data, 8'h9C);
    check("R4 full", rx_full, 1);
    pulse_data();
  endtask

  task automatic t_overrun();
    send(8'h3C, 8, 1, -1);
    send(8'hC3, 8, 1, -1);
    check("R5 ovr set", rx_ovr, 1);
    check("R5 overwrite", rx_data, 8'hC3);
    check("R6 irq_exc", irq_exc, 1);
    check("R7 irq_rx off", irq_rx, 0);
    check("R12 code exc", irq_code, exp_code(1, 1, 1, 1));
    @(negedge clk); ie_exc = 1'b0;
    @(negedge clk);
    check("R11 ie_exc off", irq_exc, 0);
    check("R7 no rx on error", irq_rx, 0);
    check("R12 code none", irq_code, exp_code(0, 1, 1, 1));
    ie_exc = 1'b1;
    pulse_data();
    check("R9 data-only read keeps ovr", rx_ovr, 1);
    check("R8 full cleared", rx_full, 0);
    pulse_status();
    pulse_status();
    pulse_data();
    check("R9 status-then-data clears", rx_ovr, 0);
  endtask

  task automatic t_config();
    cfg_word_len = LEN_W'(4);
    send(8'hB7, 8, 1, -1);
    check("R10 len frozen", rx_data, 8'hB7);
    @(negedge clk); port_en = 1'b0;
    @(negedge clk);
    t_reset();
    @(negedge clk); port_en = 1'b1;
    send(4'hB, 4, 1, -1);
    check("R10 new len", rx_data, 8'h0B);
    check("R3 full after short word", rx_full, 1);
    pulse_data();
    @(negedge clk); port_en = 1'b0;
    cfg_word_len = LEN_W'(13);
    @(negedge clk); port_en = 1'b1;
    send(8'hE1, 8, 1, -1);
    check("R3 oversize len means W", rx_data, 8'hE1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cfg_word_len = LEN_W'(8);
    @(negedge clk);
    port_en = 1'b1;
    rx_en = 1'b1; ie_exc = 1'b1; ie_rx = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gating();
    t_midsync();
    t_overrun();
    t_config();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule